// File: doc/BRIEF.md
# Two-Channel Byte-Count DMA Engine

This block moves bytes from two independent peripheral byte streams into a shared memory request port. Software programs each channel through a 32-bit register bus with a base address, a byte count, a wait count and an end mode. A write of 1 to the channel's run register starts the channel. Each accepted byte is written at the channel's current address. The current address then counts up by one and the remaining count counts down by one. When the count is exhausted, the channel stops itself and raises its status bit. A single interrupt line reports any status bit whose enable is set.

Progress is visible only through the current-address and remaining-count registers. After a normal finish, software can confirm completion by checking that the current address equals base plus count. The bytes already moved equal the base count minus the remaining count.

Both stream inputs and the memory port use valid/ready. A channel offers `s_ready` only in a cycle where it holds the memory grant and `mem_ready` is high, so a byte is consumed exactly when `s_valid && s_ready`. A source must hold its byte and `s_last` stable while valid and not ready. `mem_valid` is raised whenever some channel is eligible and its stream is valid. The memory side accepts a beat when `mem_valid && mem_ready`. Beats are not queued, so `mem_valid` may drop if the stream source withdraws.

Top module: `dma2_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `mem_valid` is low and `s_ready` is all zero.
- R2: Channel 1 registers sit 0x04 above channel 0's. Per channel: config 0x00, base address 0x10, base count 0x18, current address 0x20, remaining count 0x28, run 0x30. In config, bit 12 (transmit buffer mode), bit 8 (receive end mode) and bits 5:4 (wait) are stored and read back, and all other bits read zero. The run register reads 1 while the channel is active.
- R3: Writing 1 to bit 0 of run copies base address and base count into current address and remaining count, and activates the channel.
- R4: Each accepted byte is presented on `mem_addr` at the current address. On acceptance the current address increments by one and the remaining count decrements by one. The base count is 26 bits wide.
- R5: On the beat that takes the remaining count to zero, the channel clears its run bit and sets its status bit in the same clock. The current address then equals base plus count.
- R6: `s_ready[c]` is high only when channel c holds the grant and `mem_ready` is high. At most one `s_ready` bit is high at a time.
- R7: With wait field W, a channel idles W cycles after each accepted byte before it may request again.
- R8: When both channels are eligible in the same cycle, the grant goes to the channel that did not take the previous beat, one byte per grant.
- R9: Interrupt enable lives at 0x40 and status at 0x44, with bit 0 for channel 0 and bit 1 for channel 1. `irq` is the OR of status AND enable.
- R10: Writing to 0x48 clears the status bits written as 1 and leaves the bits written as 0 unchanged.
- R11: Writing 0 to run stops the channel at once without setting status, and no further byte is accepted.
- R12: In receive end mode, an accepted byte with `s_last` high ends the transfer early. It clears run and sets status, and the remaining count keeps the bytes that were not moved.
- R13: Starting with a base count of zero moves no data. Status is set on that same clock and run stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address, for both write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| s_valid | input | 2 | Per-channel stream byte valid |
| s_data | input | 16 | Per-channel stream byte, channel c in bits 8c+7:8c |
| s_last | input | 2 | Per-channel end-of-packet marker |
| s_ready | output | 2 | Per-channel stream byte accepted |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Byte address of the write |
| mem_data | output | 8 | Byte to write |
| irq | output | 1 | Shared end-of-transfer interrupt |

## Verification
The memory request, `s_ready` and `irq` respond in the same cycle to the inputs and to state updated at the last clock edge. Register effects appear in the cycle after the write edge, and reads are combinational. The bench changes inputs shortly after each rising edge and updates its behavioural model on that edge. It compares the ports at the falling edge, which lies between the two. Register reads are placed after a completed write or after an awaited status bit, and sampled on the falling edge of the cycle in which the read address is driven.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int NCH       = 2;
  localparam int BYTE_W    = 8;
  localparam int WAIT_W    = 2;
  localparam int CH_STRIDE = 4;

  localparam logic [7:0] A_CFG   = 8'h00;
  localparam logic [7:0] A_BADDR = 8'h10;
  localparam logic [7:0] A_BCNT  = 8'h18;
  localparam logic [7:0] A_CADDR = 8'h20;
  localparam logic [7:0] A_CCNT  = 8'h28;
  localparam logic [7:0] A_RUN   = 8'h30;
  localparam logic [7:0] A_IEN   = 8'h40;
  localparam logic [7:0] A_ISTS  = 8'h44;
  localparam logic [7:0] A_ICLR  = 8'h48;

  localparam int CFG_TXBUF_BIT = 12;
  localparam int CFG_RXEND_BIT = 8;
  localparam int CFG_WAIT_LSB  = 4;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int CH = 0,
  parameter int AW = 32,
  parameter int CW = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              fire,
  input  logic              last_in,
  output logic              elig,
  output logic              run,
  output logic              done,
  output logic [AW-1:0]     cur_addr,
  output logic [CW-1:0]     cur_cnt,
  output logic [WAIT_W-1:0] wait_cfg
);
  localparam logic [7:0] OFS = 8'(CH * CH_STRIDE);

  logic              tx_buf, rx_end;
  logic [WAIT_W-1:0] wcnt;
  logic [AW-1:0]     base_addr;
  logic [CW-1:0]     base_cnt;
  logic              we_cfg, we_ba, we_bc, we_run, start, finish;
  logic [31:0]       cfg_word;

  assign we_cfg = wr_en && (wr_addr == A_CFG + OFS);
  assign we_ba  = wr_en && (wr_addr == A_BADDR + OFS);
  assign we_bc  = wr_en && (wr_addr == A_BCNT + OFS);
  assign we_run = wr_en && (wr_addr == A_RUN + OFS);
  assign start  = we_run && wr_data[0];
  assign finish = fire && ((cur_cnt == CW'(1)) || (rx_end && last_in));
  assign done   = finish || (start && (base_cnt == '0));
  assign elig   = run && (wcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      tx_buf    <= 1'b0;
      rx_end    <= 1'b0;
      wait_cfg  <= '0;
      wcnt      <= '0;
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (fire) begin
        cur_addr <= cur_addr + AW'(1);
        cur_cnt  <= cur_cnt - CW'(1);
        wcnt     <= wait_cfg;
        if (finish) run <= 1'b0;
      end else if (wcnt != '0) begin
        wcnt <= wcnt - WAIT_W'(1);
      end
      if (we_cfg) begin
        tx_buf   <= wr_data[CFG_TXBUF_BIT];
        rx_end   <= wr_data[CFG_RXEND_BIT];
        wait_cfg <= wr_data[CFG_WAIT_LSB +: WAIT_W];
      end
      if (we_ba) base_addr <= wr_data[AW-1:0];
      if (we_bc) base_cnt  <= wr_data[CW-1:0];
      if (we_run) begin
        if (wr_data[0]) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
          wcnt     <= '0;
          run      <= (base_cnt != '0);
        end else begin
          run <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_TXBUF_BIT] = tx_buf;
    cfg_word[CFG_RXEND_BIT] = rx_end;
    cfg_word[CFG_WAIT_LSB +: WAIT_W] = wait_cfg;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CFG + OFS)   rd_data = cfg_word;
    if (rd_addr == A_BADDR + OFS) rd_data = 32'(base_addr);
    if (rd_addr == A_BCNT + OFS)  rd_data = 32'(base_cnt);
    if (rd_addr == A_CADDR + OFS) rd_data = 32'(cur_addr);
    if (rd_addr == A_CCNT + OFS)  rd_data = 32'(cur_cnt);
    if (rd_addr == A_RUN + OFS)   rd_data = 32'(run);
  end
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
  import dma2_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           adv,
  output logic [NCH-1:0] grant
);
  logic prio;

  always_comb begin
    grant = req;
    if (&req) begin
      grant = '0;
      grant[prio] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prio <= 1'b0;
    else if (adv) prio <= grant[0];
  end
endmodule

// File: rtl/dma2_intc.sv
module dma2_intc
  import dma2_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [7:0]     rd_addr,
  output logic [31:0]    rd_data,
  input  logic [NCH-1:0] done,
  output logic [NCH-1:0] sts,
  output logic           irq
);
  logic [NCH-1:0] ien, clr;

  assign clr = (wr_en && wr_addr == A_ICLR) ? wr_data[NCH-1:0] : '0;
  assign irq = |(sts & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
      sts <= '0;
    end else begin
      if (wr_en && wr_addr == A_IEN) ien <= wr_data[NCH-1:0];
      sts <= (sts & ~clr) | done;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_IEN)  rd_data = 32'(ien);
    if (rd_addr == A_ISTS) rd_data = 32'(sts);
  end
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 26
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic [NCH-1:0]        s_valid,
  input  logic [NCH*BYTE_W-1:0] s_data,
  input  logic [NCH-1:0]        s_last,
  output logic [NCH-1:0]        s_ready,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [AW-1:0]         mem_addr,
  output logic [BYTE_W-1:0]     mem_data,
  output logic                  irq
);
  logic [NCH-1:0]              run_v, elig_v, done_v, req_v, grant_v, fire_v, sts_v;
  logic [NCH-1:0][AW-1:0]      addr_v;
  logic [NCH-1:0][CW-1:0]      cnt_v;
  logic [NCH-1:0][WAIT_W-1:0]  wait_v;
  logic [NCH-1:0][31:0]        ch_rd;
  logic [31:0]                 ic_rd;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2_chan #(.CH(c), .AW(AW), .CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .rd_addr  (cfg_addr),
      .rd_data  (ch_rd[c]),
      .fire     (fire_v[c]),
      .last_in  (s_last[c]),
      .elig     (elig_v[c]),
      .run      (run_v[c]),
      .done     (done_v[c]),
      .cur_addr (addr_v[c]),
      .cur_cnt  (cnt_v[c]),
      .wait_cfg (wait_v[c])
    );
  end

  assign req_v     = elig_v & s_valid;
  assign fire_v    = grant_v & {NCH{mem_ready}};
  assign s_ready   = fire_v;
  assign mem_valid = |req_v;

  dma2_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_v),
    .adv   (|fire_v),
    .grant (grant_v)
  );

  dma2_intc u_intc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_addr (cfg_addr),
    .rd_data (ic_rd),
    .done    (done_v),
    .sts     (sts_v),
    .irq     (irq)
  );

  always_comb begin
    mem_addr  = '0;
    mem_data  = '0;
    cfg_rdata = ic_rd;
    for (int c = 0; c < NCH; c++) begin
      if (grant_v[c]) begin
        mem_addr = mem_addr | addr_v[c];
        mem_data = mem_data | s_data[c*BYTE_W +: BYTE_W];
      end
      cfg_rdata = cfg_rdata | ch_rd[c];
    end
  end
endmodule

// File: rtl/dma2_engine_chk.sv
module dma2_engine_chk
  import dma2_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 26
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [NCH-1:0]           s_ready,
  input logic                     mem_valid,
  input logic                     mem_ready,
  input logic                     irq,
  input logic [NCH-1:0]           run_v,
  input logic [NCH-1:0]           sts_v,
  input logic [NCH-1:0][CW-1:0]   cnt_v,
  input logic [NCH-1:0][WAIT_W-1:0] wait_v
);
  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_ready));

  a_r6_ready_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_ready) |-> (mem_ready && mem_valid));

  a_r9_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|sts_v));

  for (genvar c = 0; c < NCH; c++) begin : g_prop
    a_r11_idle_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v[c] |-> !s_ready[c]);

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready[c] && !cfg_we) |=> (cnt_v[c] == $past(cnt_v[c]) - CW'(1)));

    a_r5_last_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready[c] && cnt_v[c] == CW'(1) && !cfg_we) |=> (!run_v[c] && sts_v[c]));

    a_r7_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready[c] && wait_v[c] != '0 && !cfg_we) |=> !s_ready[c]);
  end
endmodule

bind dma2_engine dma2_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .s_ready   (s_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .irq       (irq),
  .run_v     (run_v),
  .sts_v     (sts_v),
  .cnt_v     (cnt_v),
  .wait_v    (wait_v)
);

// File: tb/dma2_engine_test.sv
module dma2_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  s_valid = '0;
  logic [15:0] s_data = '0;
  logic [1:0]  s_last = '0;
  logic [1:0]  s_ready;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;
  logic        irq;

  always #4 clk = ~clk;

  dma2_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq)
  );

  int vectors = 0;
  int miscompares = 0;

  // stream sources
  logic [1:0] src_on = '0;
  logic [1:0] fired = '0;
  int idx [2] = '{0, 0};
  int last_at [2] = '{-1, -1};

  always @(posedge clk) fired <= s_valid & s_ready;

  always @(posedge clk) begin
    #2;
    for (int c = 0; c < 2; c++) begin
      if (fired[c]) idx[c]++;
      if (!s_valid[c] || fired[c]) s_valid[c] = src_on[c] && ($urandom % 4 != 0);
      s_data[c*8 +: 8] = 8'(idx[c]) ^ (c == 1 ? 8'h80 : 8'h00);
      s_last[c] = (idx[c] == last_at[c]);
    end
    mem_ready = ($urandom % 4 != 0);
  end

  // behavioural reference model
  logic [31:0] m_ca [2], m_ba [2], m_cfg [2];
  logic [25:0] m_cc [2], m_bc [2];
  int          m_wc [2];
  logic [1:0]  m_en, m_sts, m_ien, setv, clrv;
  int          m_prio, mg;
  logic        fin;

  function automatic int pick();
    logic [1:0] e;
    for (int c = 0; c < 2; c++) e[c] = m_en[c] && (m_wc[c] == 0) && s_valid[c];
    if (e == 2'b11) return m_prio;
    if (e[0]) return 0;
    if (e[1]) return 1;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ca[c] = 0; m_ba[c] = 0; m_cfg[c] = 0; m_cc[c] = 0; m_bc[c] = 0; m_wc[c] = 0;
      end
      m_en = 0; m_sts = 0; m_ien = 0; m_prio = 0;
    end else begin
      setv = 0; clrv = 0;
      mg = pick();
      for (int c = 0; c < 2; c++)
        if (m_wc[c] > 0 && !(mg == c && mem_ready)) m_wc[c]--;
      if (mg >= 0 && mem_ready) begin
        fin = (m_cc[mg] == 1) || (m_cfg[mg][8] && s_last[mg]);
        m_ca[mg]++;
        m_cc[mg]--;
        m_wc[mg] = int'(m_cfg[mg][5:4]);
        m_prio = 1 - mg;
        if (fin) begin m_en[mg] = 0; setv[mg] = 1; end
      end
      if (cfg_we) begin
        for (int c = 0; c < 2; c++) begin
          if (cfg_addr == 8'(c*4))        m_cfg[c] = cfg_wdata & 32'h1130;
          if (cfg_addr == 8'(8'h10 + c*4)) m_ba[c] = cfg_wdata;
          if (cfg_addr == 8'(8'h18 + c*4)) m_bc[c] = cfg_wdata[25:0];
          if (cfg_addr == 8'(8'h30 + c*4)) begin
            if (cfg_wdata[0]) begin
              m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c]; m_wc[c] = 0;
              m_en[c] = (m_bc[c] != 0);
              if (m_bc[c] == 0) setv[c] = 1;
            end else m_en[c] = 0;
          end
        end
        if (cfg_addr == 8'h40) m_ien = cfg_wdata[1:0];
        if (cfg_addr == 8'h48) clrv = cfg_wdata[1:0];
      end
      m_sts = (m_sts & ~clrv) | setv;
    end
  end

  // per-cycle comparison against the model
  int          eg;
  logic [1:0]  exp_sr;
  always @(negedge clk) begin
    if (rst_n) begin
      eg = pick();
      vectors++;
      if (mem_valid !== (eg >= 0) ||
          (eg >= 0 && (mem_addr !== m_ca[eg] || mem_data !== s_data[eg*8 +: 8]))) begin
        miscompares++;
        $display("FAIL R4 R7 R8 mem port: actual v=%0b a=%h d=%h expected v=%0b chan=%0d",
                 mem_valid, mem_addr, mem_data, (eg >= 0), eg);
      end
      exp_sr = (eg >= 0 && mem_ready) ? (2'b01 << eg) : 2'b00;
      vectors++;
      if (s_ready !== exp_sr) begin
        miscompares++;
        $display("FAIL R6 s_ready: actual %b expected %b", s_ready, exp_sr);
      end
      vectors++;
      if (irq !== |(m_sts & m_ien)) begin
        miscompares++;
        $display("FAIL R9 irq: actual %b expected %b", irq, |(m_sts & m_ien));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(posedge clk); #2;
    cfg_addr = a;
    @(negedge clk);
    vectors++;
    if (cfg_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s reg %h: actual %h expected %h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic pchk(input string tag, input logic act, input logic exp);
    @(negedge clk);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_sts(input int c);
    for (int i = 0; i < 3000 && !m_sts[c]; i++) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R5 watchdog: actual still running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rchk("R1", 8'h00, 32'h0);
    rchk("R1", 8'h30, 32'h0);
    rchk("R1", 8'h44, 32'h0);
    pchk("R1 irq", irq, 1'b0);
    pchk("R1 mem_valid", mem_valid, 1'b0);

    // R2 config readback and channel offset
    wr(8'h40, 32'h3);
    wr(8'h00, 32'hFFFF_1134);
    rchk("R2", 8'h00, 32'h0000_1130);
    rchk("R2", 8'h04, 32'h0);
    wr(8'h00, 32'h0);

    // R3 R4 R5 single channel transfer
    wr(8'h10, 32'h1000);
    wr(8'h18, 32'd5);
    wr(8'h30, 32'h1);
    rchk("R3", 8'h20, 32'h1000);
    rchk("R3", 8'h28, 32'd5);
    rchk("R2", 8'h30, 32'h1);
    src_on[0] = 1'b1;
    wait_sts(0);
    src_on[0] = 1'b0;
    rchk("R5", 8'h20, 32'h1005);
    rchk("R4", 8'h28, 32'h0);
    rchk("R5", 8'h30, 32'h0);
    rchk("R9", 8'h44, 32'h1);
    pchk("R9 irq", irq, 1'b1);
    wr(8'h48, 32'h0);
    rchk("R10", 8'h44, 32'h1);
    wr(8'h48, 32'h1);
    rchk("R10", 8'h44, 32'h0);
    pchk("R10 irq", irq, 1'b0);

    // R7 R8 both channels, ch0 with wait 2
    wr(8'h00, 32'h20);
    wr(8'h10, 32'h2000);
    wr(8'h18, 32'd6);
    wr(8'h14, 32'h3000);
    wr(8'h1C, 32'd4);
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h1);
    src_on = 2'b11;
    wait_sts(0);
    wait_sts(1);
    src_on = 2'b00;
    rchk("R7", 8'h20, 32'h2006);
    rchk("R8", 8'h24, 32'h3004);
    rchk("R8", 8'h44, 32'h3);
    wr(8'h48, 32'h3);

    // R11 halt mid-transfer
    wr(8'h14, 32'h4000);
    wr(8'h1C, 32'd100);
    wr(8'h34, 32'h1);
    src_on[1] = 1'b1;
    repeat (20) @(posedge clk);
    wr(8'h34, 32'h0);
    repeat (10) @(posedge clk);
    rchk("R11", 8'h34, 32'h0);
    rchk("R11", 8'h44, 32'h0);
    rchk("R11", 8'h2C, {6'b0, m_cc[1]});
    src_on[1] = 1'b0;

    // R12 receive end mode: s_last on third byte
    wr(8'h00, 32'h100);
    wr(8'h10, 32'h5000);
    wr(8'h18, 32'd10);
    last_at[0] = idx[0] + 2;
    wr(8'h30, 32'h1);
    src_on[0] = 1'b1;
    wait_sts(0);
    src_on[0] = 1'b0;
    rchk("R12", 8'h28, 32'd7);
    rchk("R12", 8'h20, 32'h5003);
    rchk("R12", 8'h30, 32'h0);
    wr(8'h48, 32'h1);
    last_at[0] = -1;

    // R13 zero count start
    wr(8'h14, 32'h6000);
    wr(8'h1C, 32'd0);
    wr(8'h34, 32'h1);
    rchk("R13", 8'h34, 32'h0);
    rchk("R13", 8'h44, 32'h2);
    rchk("R13", 8'h24, 32'h6000);
    pchk("R13 irq", irq, 1'b1);

    summary();
  end
endmodule